// File: doc/BRIEF.md
# Minimal Machine-Mode Control and Status Register Unit

This block holds the machine-level control and status state of a small 32-bit microcontroller core that runs in machine mode only. The core hands it a register access taken straight from an instruction: a 12-bit register number from the immediate field, an operation (read, write, set bits, clear bits) and an operand. One cycle later the block returns the old register value, or flags the access as illegal. No general-register read is needed to pick the target register.

The block also handles trap entry and return. An exception pulse, or a core pulse accepting an interrupt, saves the even-aligned PC, records the cause and fault value, and masks interrupts. The trap entry address is always on an output. A return pulse restores the interrupt enable, and the saved PC is always on a second output. A registered request tells the core that an enabled interrupt is pending. External interrupts win over timer interrupts. Only the smallest useful set of registers keeps state. Identification, delegation and counter-enable registers read as zero, and the trap vector is a build-time constant unless a parameter makes it writable.

Top module: `mcsr_unit`

## Requirements
- R1: After synchronous reset, `csr_rdata`, `csr_illegal` and `irq_pending` are 0. Status (0x300), interrupt enable (0x304), scratch (0x340), saved PC (0x341) and cause (0x342) all read 0.
- R2: `csr_op` encodes 0 read, 1 write, 2 set, 3 clear. Every operation returns the old value. A write stores the operand, a set stores old|operand and a clear stores old&~operand. A set or clear with a zero operand performs no write, so it is legal even at a read-only number.
- R3: Register numbers 0x302, 0x303, 0x306 and 0xF11 to 0xF14 always read 0. Writes to 0x302, 0x303 and 0x306 are legal and have no effect.
- R4: The ISA register (0x301) reads as a single set bit: bit 8 for the full integer base, or bit 4 for the reduced base when `BASE_E` is set.
- R5: An access to a number outside the listed set is illegal. So is a write to any number whose top two bits are 11. An illegal access sets `csr_illegal` in the following cycle with `csr_rdata` 0, and it changes no state.
- R6: The status register stores only the global enable (bit 3) and the previous enable (bit 7). The enable register stores only the external enable (bit 11) and the timer enable (bit 7). The pending register (0x344) shows `ext_irq` at bit 11 and `tmr_irq` at bit 7, and writes to it have no effect. All other bits read 0.
- R7: With `TVEC_FIXED` set, the trap vector register (0x305) and `trap_vector` both give `TVEC_ADDR`, and writes to 0x305 have no effect.
- R8: The saved PC always has bit 0 clear, both after a register write and after a trap. `ret_pc` shows the saved PC.
- R9: An `exc_valid` pulse stores `cur_pc` with bit 0 cleared into the saved PC, and the zero-extended `exc_code` into the cause register with bit 31 clear. It stores `exc_tval` as the fault value, copies the global enable into the previous enable, and clears the global enable.
- R10: An `irq_take` pulse saves the PC and the enables as in R9. It sets the fault value to 0 and stores a cause with bit 31 set: code 11 when the external line is pending and enabled, otherwise code 7 for the timer.
- R11: An `mret` pulse copies the previous enable into the global enable and sets the previous enable to 1.
- R12: `irq_pending` is 1 one cycle after a cycle in which the global enable is set and at least one line (external or timer) is both high and enabled.
- R13: The cycle counter (low 0xB00, high 0xB80) advances on every clock. The retired-instruction counter (low 0xB02, high 0xB82) advances on each cycle with `retire` high. Both are 64 bits wide, and each half can be written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_req | input | 1 | Register access request |
| csr_op | input | 2 | 0 read, 1 write, 2 set, 3 clear |
| csr_addr | input | 12 | Register number from the instruction immediate |
| csr_wdata | input | XLEN | Access operand |
| csr_rdata | output | XLEN | Old register value, one cycle after the request |
| csr_illegal | output | 1 | Illegal access flag, one cycle after the request |
| retire | input | 1 | One instruction retired this cycle |
| exc_valid | input | 1 | Exception trap entry pulse |
| exc_code | input | CODE_W | Exception cause code |
| exc_tval | input | XLEN | Exception fault value |
| cur_pc | input | XLEN | PC to save on trap entry |
| irq_take | input | 1 | Core accepts the pending interrupt |
| mret | input | 1 | Trap return pulse |
| ext_irq | input | 1 | External interrupt line |
| tmr_irq | input | 1 | Timer interrupt line |
| trap_vector | output | XLEN | Trap entry address |
| ret_pc | output | XLEN | Saved PC for trap return |
| irq_pending | output | 1 | Registered interrupt request |

## Verification
An access applied before a clock edge returns its data and its illegal flag just after that edge. Any state it writes is visible to a read on the next edge. Trap and return pulses update state on the edge where they are sampled. `irq_pending` trails the enables and the lines by one more edge, so the bench waits an extra cycle before it samples that output. The bench drives and samples only at falling edges. It checks counter behaviour through the difference between two reads, using the number of edges between the two read edges (or the number of edges with `retire` high).

// File: rtl/mcsr_pkg.sv
package mcsr_pkg;

  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_WRITE = 2'd1,
    OP_SET   = 2'd2,
    OP_CLEAR = 2'd3
  } csr_op_e;

  typedef enum logic [3:0] {
    SEL_NONE,
    SEL_ZERO,
    SEL_STATUS,
    SEL_ISA,
    SEL_IE,
    SEL_TVEC,
    SEL_SCRATCH,
    SEL_EPC,
    SEL_CAUSE,
    SEL_TVAL,
    SEL_IP,
    SEL_CYC_LO,
    SEL_CYC_HI,
    SEL_RET_LO,
    SEL_RET_HI
  } csr_sel_e;

  localparam int BIT_GIE   = 3;
  localparam int BIT_PIE   = 7;
  localparam int BIT_EXT   = 11;
  localparam int BIT_TMR   = 7;
  localparam int CODE_EXT  = 11;
  localparam int CODE_TMR  = 7;

endpackage

// File: rtl/mcsr_decode.sv
module mcsr_decode
  import mcsr_pkg::*;
(
  input  logic [11:0] addr,
  input  logic        wants_wr,
  output csr_sel_e    sel,
  output logic        illegal
);

  always_comb begin
    case (addr)
      12'h300: sel = SEL_STATUS;
      12'h301: sel = SEL_ISA;
      12'h302, 12'h303, 12'h306: sel = SEL_ZERO;
      12'h304: sel = SEL_IE;
      12'h305: sel = SEL_TVEC;
      12'h340: sel = SEL_SCRATCH;
      12'h341: sel = SEL_EPC;
      12'h342: sel = SEL_CAUSE;
      12'h343: sel = SEL_TVAL;
      12'h344: sel = SEL_IP;
      12'hB00: sel = SEL_CYC_LO;
      12'hB80: sel = SEL_CYC_HI;
      12'hB02: sel = SEL_RET_LO;
      12'hB82: sel = SEL_RET_HI;
      12'hF11, 12'hF12, 12'hF13, 12'hF14: sel = SEL_ZERO;
      default: sel = SEL_NONE;
    endcase
    illegal = (sel == SEL_NONE) || (wants_wr && (addr[11:10] == 2'b11));
  end

endmodule

// File: rtl/mcsr_counter.sv
module mcsr_counter #(
  parameter int HALF = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inc,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [HALF-1:0]   wdata,
  output logic [2*HALF-1:0] count
);

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
    end else if (wr_lo) begin
      count <= {count[2*HALF-1:HALF], wdata};
    end else if (wr_hi) begin
      count <= {wdata, count[HALF-1:0]};
    end else if (inc) begin
      count <= count + 1'b1;
    end
  end

endmodule

// File: rtl/mcsr_irq_arb.sv
module mcsr_irq_arb
  import mcsr_pkg::*;
#(
  parameter int CODE_W = 5
) (
  input  logic              ext,
  input  logic              tmr,
  input  logic              meie,
  input  logic              mtie,
  input  logic              gie,
  output logic              req,
  output logic [CODE_W-1:0] code
);

  logic ext_hit, tmr_hit;

  always_comb begin
    ext_hit = ext && meie;
    tmr_hit = tmr && mtie;
    req     = gie && (ext_hit || tmr_hit);
    code    = ext_hit ? CODE_W'(CODE_EXT) : CODE_W'(CODE_TMR);
  end

endmodule

// File: rtl/mcsr_unit.sv
module mcsr_unit
  import mcsr_pkg::*;
#(
  parameter int               XLEN       = 32,
  parameter bit               BASE_E     = 1'b0,
  parameter bit               TVEC_FIXED = 1'b1,
  parameter logic [XLEN-1:0]  TVEC_ADDR  = 32'h0001_0000,
  parameter int               CODE_W     = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              csr_req,
  input  logic [1:0]        csr_op,
  input  logic [11:0]       csr_addr,
  input  logic [XLEN-1:0]   csr_wdata,
  output logic [XLEN-1:0]   csr_rdata,
  output logic              csr_illegal,
  input  logic              retire,
  input  logic              exc_valid,
  input  logic [CODE_W-1:0] exc_code,
  input  logic [XLEN-1:0]   exc_tval,
  input  logic [XLEN-1:0]   cur_pc,
  input  logic              irq_take,
  input  logic              mret,
  input  logic              ext_irq,
  input  logic              tmr_irq,
  output logic [XLEN-1:0]   trap_vector,
  output logic [XLEN-1:0]   ret_pc,
  output logic              irq_pending
);

  localparam int ISA_BIT = BASE_E ? 4 : 8;
  localparam int NCNT    = 2;

  csr_op_e          op;
  csr_sel_e         sel;
  logic             illegal, wants_wr, wr_en;
  logic [XLEN-1:0]  old_val, new_val, tvec_val;
  logic [XLEN-1:0]  cause_exc, cause_irq;
  logic             gie_q, pie_q, meie_q, mtie_q;
  logic [XLEN-1:0]  scratch_q, epc_q, cause_q, tval_q;
  logic [XLEN-1:0]  rdata_q;
  logic             illegal_q, irq_q;
  logic             arb_req;
  logic [CODE_W-1:0] arb_code;
  logic [2*XLEN-1:0] cnt [NCNT];

  assign op       = csr_op_e'(csr_op);
  assign wants_wr = (op == OP_WRITE) ||
                    (((op == OP_SET) || (op == OP_CLEAR)) && (csr_wdata != '0));

  mcsr_decode dec_i (
    .addr     (csr_addr),
    .wants_wr (wants_wr),
    .sel      (sel),
    .illegal  (illegal)
  );

  assign wr_en = csr_req && wants_wr && !illegal;

  mcsr_irq_arb #(.CODE_W(CODE_W)) arb_i (
    .ext  (ext_irq),
    .tmr  (tmr_irq),
    .meie (meie_q),
    .mtie (mtie_q),
    .gie  (gie_q),
    .req  (arb_req),
    .code (arb_code)
  );

  for (genvar g = 0; g < NCNT; g++) begin : g_cnt
    localparam csr_sel_e LO_SEL = (g == 0) ? SEL_CYC_LO : SEL_RET_LO;
    localparam csr_sel_e HI_SEL = (g == 0) ? SEL_CYC_HI : SEL_RET_HI;
    mcsr_counter #(.HALF(XLEN)) cnt_i (
      .clk   (clk),
      .rst   (rst),
      .inc   ((g == 0) ? 1'b1 : retire),
      .wr_lo (wr_en && (sel == LO_SEL)),
      .wr_hi (wr_en && (sel == HI_SEL)),
      .wdata (new_val),
      .count (cnt[g])
    );
  end

  if (TVEC_FIXED) begin : g_tvec_fixed
    assign tvec_val = TVEC_ADDR;
  end else begin : g_tvec_reg
    logic [XLEN-1:0] tvec_q;
    always_ff @(posedge clk) begin
      if (rst) tvec_q <= TVEC_ADDR;
      else if (wr_en && (sel == SEL_TVEC)) tvec_q <= {new_val[XLEN-1:2], 2'b00};
    end
    assign tvec_val = tvec_q;
  end

  always_comb begin
    old_val = '0;
    case (sel)
      SEL_STATUS: begin
        old_val[BIT_GIE] = gie_q;
        old_val[BIT_PIE] = pie_q;
      end
      SEL_ISA:     old_val[ISA_BIT] = 1'b1;
      SEL_IE: begin
        old_val[BIT_EXT] = meie_q;
        old_val[BIT_TMR] = mtie_q;
      end
      SEL_TVEC:    old_val = tvec_val;
      SEL_SCRATCH: old_val = scratch_q;
      SEL_EPC:     old_val = epc_q;
      SEL_CAUSE:   old_val = cause_q;
      SEL_TVAL:    old_val = tval_q;
      SEL_IP: begin
        old_val[BIT_EXT] = ext_irq;
        old_val[BIT_TMR] = tmr_irq;
      end
      SEL_CYC_LO:  old_val = cnt[0][XLEN-1:0];
      SEL_CYC_HI:  old_val = cnt[0][2*XLEN-1:XLEN];
      SEL_RET_LO:  old_val = cnt[1][XLEN-1:0];
      SEL_RET_HI:  old_val = cnt[1][2*XLEN-1:XLEN];
      default:     old_val = '0;
    endcase
    case (op)
      OP_WRITE: new_val = csr_wdata;
      OP_SET:   new_val = old_val | csr_wdata;
      OP_CLEAR: new_val = old_val & ~csr_wdata;
      default:  new_val = old_val;
    endcase
    cause_exc = '0;
    cause_exc[CODE_W-1:0] = exc_code;
    cause_irq = '0;
    cause_irq[CODE_W-1:0] = arb_code;
    cause_irq[XLEN-1] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gie_q <= 1'b0;  pie_q <= 1'b0;
      meie_q <= 1'b0; mtie_q <= 1'b0;
      scratch_q <= '0; epc_q <= '0; cause_q <= '0; tval_q <= '0;
      rdata_q <= '0; illegal_q <= 1'b0; irq_q <= 1'b0;
    end else begin
      if (wr_en) begin
        case (sel)
          SEL_STATUS: begin
            gie_q <= new_val[BIT_GIE];
            pie_q <= new_val[BIT_PIE];
          end
          SEL_IE: begin
            meie_q <= new_val[BIT_EXT];
            mtie_q <= new_val[BIT_TMR];
          end
          SEL_SCRATCH: scratch_q <= new_val;
          SEL_EPC:     epc_q     <= {new_val[XLEN-1:1], 1'b0};
          SEL_CAUSE:   cause_q   <= new_val;
          SEL_TVAL:    tval_q    <= new_val;
          default: ;
        endcase
      end
      if (exc_valid || irq_take) begin
        epc_q   <= {cur_pc[XLEN-1:1], 1'b0};
        pie_q   <= gie_q;
        gie_q   <= 1'b0;
        cause_q <= exc_valid ? cause_exc : cause_irq;
        tval_q  <= exc_valid ? exc_tval : '0;
      end else if (mret) begin
        gie_q <= pie_q;
        pie_q <= 1'b1;
      end
      rdata_q   <= (csr_req && !illegal) ? old_val : '0;
      illegal_q <= csr_req && illegal;
      irq_q     <= arb_req;
    end
  end

  assign csr_rdata   = rdata_q;
  assign csr_illegal = illegal_q;
  assign irq_pending = irq_q;
  assign trap_vector = tvec_val;
  assign ret_pc      = epc_q;

endmodule

// File: rtl/mcsr_checks.sv
module mcsr_checks #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            csr_req,
  input logic            csr_illegal,
  input logic [XLEN-1:0] csr_rdata,
  input logic            exc_valid,
  input logic            irq_take,
  input logic            mret,
  input logic            ext_irq,
  input logic            tmr_irq,
  input logic            irq_pending,
  input logic            gie,
  input logic            pie
);

  // R5: the flag only follows a request
  a_r5_flag_after_req: assert property (@(posedge clk) disable iff (rst)
    csr_illegal |-> $past(csr_req));

  // R5: illegal accesses return no data
  a_r5_illegal_no_data: assert property (@(posedge clk) disable iff (rst)
    csr_illegal |-> (csr_rdata == '0));

  // R9 / R10: trap entry masks and saves the enable
  a_r9_trap_masks: assert property (@(posedge clk) disable iff (rst)
    (exc_valid || irq_take) |=> (!gie && (pie == $past(gie))));

  // R11: return restores the enable
  a_r11_ret_restores: assert property (@(posedge clk) disable iff (rst)
    (mret && !exc_valid && !irq_take) |=> (pie && (gie == $past(pie))));

  // R12: a request needs a line and the global enable
  a_r12_req_needs_line: assert property (@(posedge clk) disable iff (rst)
    irq_pending |-> $past(ext_irq || tmr_irq));

  a_r12_req_needs_gie: assert property (@(posedge clk) disable iff (rst)
    irq_pending |-> $past(gie));

endmodule

bind mcsr_unit mcsr_checks #(.XLEN(XLEN)) chk_i (
  .clk         (clk),
  .rst         (rst),
  .csr_req     (csr_req),
  .csr_illegal (csr_illegal),
  .csr_rdata   (csr_rdata),
  .exc_valid   (exc_valid),
  .irq_take    (irq_take),
  .mret        (mret),
  .ext_irq     (ext_irq),
  .tmr_irq     (tmr_irq),
  .irq_pending (irq_pending),
  .gie         (gie_q),
  .pie         (pie_q)
);

// File: tb/mcsr_unit_tb.sv
`timescale 1ns/1ps
module mcsr_unit_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        csr_req = 1'b0;
  logic [1:0]  csr_op = 2'd0;
  logic [11:0] csr_addr = '0;
  logic [31:0] csr_wdata = '0;
  logic [31:0] csr_rdata;
  logic        csr_illegal;
  logic        retire = 1'b0;
  logic        exc_valid = 1'b0;
  logic [4:0]  exc_code = '0;
  logic [31:0] exc_tval = '0;
  logic [31:0] cur_pc = '0;
  logic        irq_take = 1'b0;
  logic        mret = 1'b0;
  logic        ext_irq = 1'b0;
  logic        tmr_irq = 1'b0;
  logic [31:0] trap_vector;
  logic [31:0] ret_pc;
  logic        irq_pending;

  int errors = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  mcsr_unit dut_i (
    .clk(clk), .rst(rst), .csr_req(csr_req), .csr_op(csr_op),
    .csr_addr(csr_addr), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
    .csr_illegal(csr_illegal), .retire(retire), .exc_valid(exc_valid),
    .exc_code(exc_code), .exc_tval(exc_tval), .cur_pc(cur_pc),
    .irq_take(irq_take), .mret(mret), .ext_irq(ext_irq), .tmr_irq(tmr_irq),
    .trap_vector(trap_vector), .ret_pc(ret_pc), .irq_pending(irq_pending)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic acc(input logic [1:0] op, input logic [11:0] a, input logic [31:0] d,
                     output logic [31:0] rd, output logic il);
    @(negedge clk);
    csr_req = 1'b1; csr_op = op; csr_addr = a; csr_wdata = d;
    @(negedge clk);
    csr_req = 1'b0; csr_op = 2'd0; csr_wdata = '0;
    rd = csr_rdata; il = csr_illegal;
  endtask

  task automatic rd_chk(input string tag, input logic [11:0] a, input logic [31:0] exp);
    logic [31:0] v; logic il;
    acc(2'd0, a, 32'h0, v, il);
    chk(tag, v, exp);
  endtask

  function automatic bit listed(input logic [11:0] a);
    case (a)
      12'h300, 12'h301, 12'h302, 12'h303, 12'h304, 12'h305, 12'h306,
      12'h340, 12'h341, 12'h342, 12'h343, 12'h344,
      12'hB00, 12'hB80, 12'hB02, 12'hB82,
      12'hF11, 12'hF12, 12'hF13, 12'hF14: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic bit zero_reg(input logic [11:0] a);
    return (a == 12'h302) || (a == 12'h303) || (a == 12'h306) ||
           (a >= 12'hF11 && a <= 12'hF14);
  endfunction

  task automatic pulse_exc(input logic [31:0] pc, input logic [4:0] code, input logic [31:0] tv);
    @(negedge clk);
    exc_valid = 1'b1; cur_pc = pc; exc_code = code; exc_tval = tv;
    @(negedge clk);
    exc_valid = 1'b0;
  endtask

  task automatic pulse_take(input logic [31:0] pc);
    @(negedge clk);
    irq_take = 1'b1; cur_pc = pc;
    @(negedge clk);
    irq_take = 1'b0;
  endtask

  task automatic pulse_mret();
    @(negedge clk);
    mret = 1'b1;
    @(negedge clk);
    mret = 1'b0;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] v, c0, c1;
    logic il;

    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 irq_pending", {31'b0, irq_pending}, 32'h0);
    chk("R1 illegal", {31'b0, csr_illegal}, 32'h0);
    chk("R1 rdata", csr_rdata, 32'h0);
    rd_chk("R1 status", 12'h300, 32'h0);
    rd_chk("R1 enable", 12'h304, 32'h0);
    rd_chk("R1 scratch", 12'h340, 32'h0);
    rd_chk("R1 epc", 12'h341, 32'h0);
    rd_chk("R1 cause", 12'h342, 32'h0);

    // R4 ISA bit
    rd_chk("R4 isa", 12'h301, 32'h0000_0100);

    // R7 fixed vector
    acc(2'd1, 12'h305, 32'h0000_2000, v, il);
    chk("R7 vector old", v, 32'h0001_0000);
    chk("R7 vector legal", {31'b0, il}, 32'h0);
    rd_chk("R7 vector kept", 12'h305, 32'h0001_0000);
    chk("R7 trap_vector port", trap_vector, 32'h0001_0000);

    // R2 read-modify-write forms
    acc(2'd1, 12'h340, 32'hA5A5_0F0F, v, il);
    chk("R2 write old", v, 32'h0);
    acc(2'd2, 12'h340, 32'h0000_F000, v, il);
    chk("R2 set old", v, 32'hA5A5_0F0F);
    rd_chk("R2 after set", 12'h340, 32'hA5A5_FF0F);
    acc(2'd3, 12'h340, 32'hA500_0000, v, il);
    chk("R2 clear old", v, 32'hA5A5_FF0F);
    rd_chk("R2 after clear", 12'h340, 32'h00A5_FF0F);
    acc(2'd2, 12'hF11, 32'h0, v, il);
    chk("R2 zero set no write", {31'b0, il}, 32'h0);
    acc(2'd3, 12'hF13, 32'h0, v, il);
    chk("R2 zero clear no write", {31'b0, il}, 32'h0);
    acc(2'd1, 12'hF11, 32'h0, v, il);
    chk("R5 write to read-only", {31'b0, il}, 32'h1);

    // R5 / R3 sweep of every register number
    for (int a = 0; a < 4096; a++) begin
      acc(2'd0, 12'(a), 32'h0, v, il);
      chk("R5 read sweep illegal", {31'b0, il}, {31'b0, ~listed(12'(a))});
      if (!listed(12'(a)) || zero_reg(12'(a)))
        chk("R3 sweep reads zero", v, 32'h0);
    end
    for (int a = 12'hC00; a < 4096; a++) begin
      acc(2'd1, 12'(a), 32'h1, v, il);
      chk("R5 read-only region write", {31'b0, il}, 32'h1);
    end
    acc(2'd1, 12'h345, 32'h1234_5678, v, il);
    chk("R5 unlisted write flagged", {31'b0, il}, 32'h1);
    rd_chk("R5 no state change", 12'h340, 32'h00A5_FF0F);

    // R3 writes to zero registers
    for (int i = 0; i < 3; i++) begin
      logic [11:0] za;
      za = (i == 0) ? 12'h302 : (i == 1) ? 12'h303 : 12'h306;
      acc(2'd1, za, 32'hFFFF_FFFF, v, il);
      chk("R3 zero reg write legal", {31'b0, il}, 32'h0);
      rd_chk("R3 zero reg stays zero", za, 32'h0);
    end

    // R6 stored bits
    acc(2'd1, 12'h300, 32'hFFFF_FFFF, v, il);
    rd_chk("R6 status bits", 12'h300, 32'h0000_0088);
    acc(2'd1, 12'h304, 32'hFFFF_FFFF, v, il);
    rd_chk("R6 enable bits", 12'h304, 32'h0000_0880);
    acc(2'd3, 12'h300, 32'hFFFF_FFFF, v, il);
    rd_chk("R6 status cleared", 12'h300, 32'h0);
    ext_irq = 1'b1;
    rd_chk("R6 pending ext", 12'h344, 32'h0000_0800);
    ext_irq = 1'b0; tmr_irq = 1'b1;
    rd_chk("R6 pending tmr", 12'h344, 32'h0000_0080);
    tmr_irq = 1'b0;
    acc(2'd1, 12'h344, 32'hFFFF_FFFF, v, il);
    rd_chk("R6 pending write ignored", 12'h344, 32'h0);

    // R8 saved PC alignment
    acc(2'd1, 12'h341, 32'h0000_1235, v, il);
    rd_chk("R8 epc even", 12'h341, 32'h0000_1234);
    chk("R8 ret_pc", ret_pc, 32'h0000_1234);

    // R9 exception entry
    acc(2'd1, 12'h300, 32'h0000_0008, v, il);
    pulse_exc(32'h0000_0401, 5'd2, 32'hDEAD_BEEF);
    rd_chk("R9 epc", 12'h341, 32'h0000_0400);
    rd_chk("R9 cause", 12'h342, 32'h0000_0002);
    rd_chk("R9 tval", 12'h343, 32'hDEAD_BEEF);
    rd_chk("R9 status", 12'h300, 32'h0000_0080);

    // R11 return
    chk("R11 ret_pc", ret_pc, 32'h0000_0400);
    pulse_mret();
    rd_chk("R11 status", 12'h300, 32'h0000_0088);

    // R12 / R10 interrupts, external over timer
    @(negedge clk);
    ext_irq = 1'b1; tmr_irq = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R12 request raised", {31'b0, irq_pending}, 32'h1);
    pulse_take(32'h0000_0900);
    rd_chk("R10 cause ext", 12'h342, 32'h8000_000B);
    rd_chk("R10 tval zero", 12'h343, 32'h0);
    rd_chk("R10 epc", 12'h341, 32'h0000_0900);
    rd_chk("R10 status", 12'h300, 32'h0000_0080);
    chk("R12 masked after entry", {31'b0, irq_pending}, 32'h0);
    pulse_mret();
    ext_irq = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R12 timer request", {31'b0, irq_pending}, 32'h1);
    pulse_take(32'h0000_0A00);
    rd_chk("R10 cause tmr", 12'h342, 32'h8000_0007);
    pulse_mret();
    tmr_irq = 1'b0;
    acc(2'd1, 12'h304, 32'h0000_0080, v, il);
    ext_irq = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R12 disabled line no request", {31'b0, irq_pending}, 32'h0);
    ext_irq = 1'b0;

    // R13 counters
    acc(2'd0, 12'hB00, 32'h0, c0, il);
    repeat (10) @(negedge clk);
    acc(2'd0, 12'hB00, 32'h0, c1, il);
    chk("R13 cycle delta", c1 - c0, 32'd12);
    acc(2'd0, 12'hB02, 32'h0, c0, il);
    retire = 1'b1;
    repeat (7) @(negedge clk);
    retire = 1'b0;
    acc(2'd0, 12'hB02, 32'h0, c1, il);
    chk("R13 retire delta", c1 - c0, 32'd7);
    repeat (5) @(negedge clk);
    acc(2'd0, 12'hB02, 32'h0, c0, il);
    chk("R13 no retire no count", c0 - c1, 32'd0);
    acc(2'd1, 12'hB80, 32'd5, v, il);
    acc(2'd1, 12'hB00, 32'hFFFF_FFF0, v, il);
    repeat (20) @(negedge clk);
    rd_chk("R13 cycle carry into high", 12'hB80, 32'd6);

    summary();
    $finish;
  end

endmodule